// File: doc/BRIEF.md
# Byte and Halfword Lane Steering

This block aligns load and store data between a 32-bit big-endian datapath and a byte-addressed memory bus. It works at two points in the pipeline. When a store executes, it forms the lane offset from the low two bits of the two address operands. It then copies the byte or halfword being stored into every lane of the write bus and raises only the byte enables that the access touches. The write data and the enables go out combinationally in the execute stage. A registered copy of both is held for the memory stage and is updated whenever the execute stage advances.

When a load reaches writeback, the pipeline gives the block back the offset and size flags it saved for that load. The block moves the addressed byte or halfword of the raw read word down to the least significant end and fills the upper bits with zeros. Word accesses pass through unchanged.

Lane numbering is big-endian: lane 0 is bits 31:24 and lane 3 is bits 7:0. Byte enable bit `i` gates bits `8i+7:8i`, so lane 0 is enable bit 3.

Top module: `lane_steer`

## Requirements
- R1: `ex_lane_ofs` equals `(ex_opa_lo + ex_opb_lo) mod 4` for every pair of operand bits.
- R2: A byte store (`ex_byte`=1) drives `ex_wdata` with `ex_store_val[7:0]` in all four lanes, and drives `ex_ben` with one bit set, equal to `4'b1000 >> ex_lane_ofs`.
- R3: A halfword store (`ex_half`=1, `ex_byte`=0) drives `ex_wdata` with `ex_store_val[15:0]` in both halves. `ex_ben` is `4'b1100` when offset bit 1 is 0 and `4'b0011` when it is 1; offset bit 0 has no effect.
- R4: A word store (both flags 0) passes `ex_store_val` to `ex_wdata` unchanged, with `ex_ben` = `4'b1111`.
- R5: When `ex_byte` and `ex_half` are both 1, the access is treated as a byte access.
- R6: `mem_wdata` and `mem_ben` reset to zero. On a clock edge with `ex_adv`=1 they take the execute-stage values; on an edge with `ex_adv`=0 they hold.
- R7: A byte load (`wb_byte`=1) returns the lane selected by `wb_lane_ofs` in bits 7:0, with bits 31:8 zero. Offset 0 selects bits 31:24 and offset 3 selects bits 7:0. `wb_byte` takes priority over `wb_half`.
- R8: A halfword load (`wb_half`=1, `wb_byte`=0) returns bits 31:16 when `wb_lane_ofs[1]`=0 and bits 15:0 when it is 1, placed in bits 15:0 with the upper half zero. `wb_lane_ofs[0]` has no effect.
- R9: A word load (both flags 0) returns `wb_rdata_raw` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ex_adv | input | 1 | Execute stage advances this cycle |
| ex_byte | input | 1 | Execute access is one byte |
| ex_half | input | 1 | Execute access is one halfword |
| ex_opa_lo | input | 2 | Low bits of the first address operand |
| ex_opb_lo | input | 2 | Low bits of the second address operand |
| ex_store_val | input | 32 | Store value, right-aligned |
| ex_lane_ofs | output | 2 | Lane offset formed in execute |
| ex_wdata | output | 32 | Mirrored write data, execute stage |
| ex_ben | output | 4 | Byte enables, execute stage |
| mem_wdata | output | 32 | Registered write data, memory stage |
| mem_ben | output | 4 | Registered byte enables, memory stage |
| wb_lane_ofs | input | 2 | Offset saved for the writeback load |
| wb_byte | input | 1 | Writeback load is one byte |
| wb_half | input | 1 | Writeback load is one halfword |
| wb_rdata_raw | input | 32 | Raw read word from the bus |
| wb_rdata | output | 32 | Right-aligned, zero-filled load data |

## Verification
The only internal state is the memory-stage register. A fault there shows up at `mem_wdata` and `mem_ben` on the first edge after the faulty capture or hold. It appears either as data from the wrong cycle, or as a value that moved while `ex_adv` was low. The rest of the block is combinational, so a wrong offset sum, lane order or fill appears on the execute or writeback outputs in the same cycle as the input that causes it. The bench therefore checks those outputs directly for every offset and every access size.

// File: rtl/lane_steer_pkg.sv
package lane_steer_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        SZ_WORD = 2'd0,
        SZ_HALF = 2'd1,
        SZ_BYTE = 2'd2
    } acc_size_e;

    // byte flag wins when both flags are raised
    function automatic acc_size_e decode_size(input logic is_byte, input logic is_half);
        if (is_byte)      return SZ_BYTE;
        else if (is_half) return SZ_HALF;
        else              return SZ_WORD;
    endfunction

endpackage

// File: rtl/lane_offset.sv
module lane_offset #(
    parameter int OFS_W = 2
) (
    input  logic [OFS_W-1:0] opa_lo,
    input  logic [OFS_W-1:0] opb_lo,
    output logic [OFS_W-1:0] lane_ofs
);
    // carry out of the low bits is discarded: modulo lane count
    always_comb begin
        lane_ofs = opa_lo + opb_lo;
    end
endmodule

// File: rtl/store_mirror.sv
module store_mirror
    import lane_steer_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int NLANE = DATA_W / BYTE_W,
    localparam int OFS_W = $clog2(NLANE)
) (
    input  acc_size_e          size,
    input  logic [OFS_W-1:0]   lane_ofs,
    input  logic [DATA_W-1:0]  store_val,
    output logic [DATA_W-1:0]  wdata,
    output logic [NLANE-1:0]   ben
);
    logic [NLANE-1:0] ben_byte;
    logic [NLANE-1:0] ben_half;
    logic [DATA_W-1:0] mir_byte;
    logic [DATA_W-1:0] mir_half;

    for (genvar i = 0; i < NLANE; i++) begin : g_lane
        // bus lane i holds big-endian lane NLANE-1-i
        localparam int BE_IDX = NLANE - 1 - i;
        assign ben_byte[i] = (OFS_W'(BE_IDX) == lane_ofs);
        assign ben_half[i] = (OFS_W'(BE_IDX >> 1) == (lane_ofs >> 1));
        assign mir_byte[i*BYTE_W +: BYTE_W] = store_val[BYTE_W-1:0];
        assign mir_half[i*BYTE_W +: BYTE_W] = store_val[(i % 2)*BYTE_W +: BYTE_W];
    end

    always_comb begin
        unique case (size)
            SZ_BYTE: begin
                wdata = mir_byte;
                ben   = ben_byte;
            end
            SZ_HALF: begin
                wdata = mir_half;
                ben   = ben_half;
            end
            default: begin
                wdata = store_val;
                ben   = '1;
            end
        endcase
    end
endmodule

// File: rtl/mem_stage_reg.sv
module mem_stage_reg #(
    parameter int DATA_W = 32,
    parameter int NLANE  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic [DATA_W-1:0] wdata_in,
    input  logic [NLANE-1:0]  ben_in,
    output logic [DATA_W-1:0] wdata_out,
    output logic [NLANE-1:0]  ben_out
);
    typedef struct packed {
        logic [DATA_W-1:0] wdata;
        logic [NLANE-1:0]  ben;
    } stage_t;

    stage_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (adv) begin
            st_d.wdata = wdata_in;
            st_d.ben   = ben_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wdata_out = st_q.wdata;
    assign ben_out   = st_q.ben;
endmodule

// File: rtl/load_align.sv
module load_align
    import lane_steer_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int NLANE = DATA_W / BYTE_W,
    localparam int NHALF = NLANE / 2,
    localparam int OFS_W = $clog2(NLANE)
) (
    input  acc_size_e          size,
    input  logic [OFS_W-1:0]   lane_ofs,
    input  logic [DATA_W-1:0]  raw,
    output logic [DATA_W-1:0]  rdata
);
    logic [BYTE_W-1:0]   lane_be [NLANE];
    logic [2*BYTE_W-1:0] half_be [NHALF];
    logic [OFS_W-2:0]    half_idx;

    for (genvar k = 0; k < NLANE; k++) begin : g_lane
        assign lane_be[k] = raw[DATA_W-1-k*BYTE_W -: BYTE_W];
    end
    for (genvar h = 0; h < NHALF; h++) begin : g_half
        assign half_be[h] = raw[DATA_W-1-h*2*BYTE_W -: 2*BYTE_W];
    end

    assign half_idx = lane_ofs[OFS_W-1:1];

    always_comb begin
        rdata = '0;
        unique case (size)
            SZ_BYTE: rdata[BYTE_W-1:0]   = lane_be[lane_ofs];
            SZ_HALF: rdata[2*BYTE_W-1:0] = half_be[half_idx];
            default: rdata               = raw;
        endcase
    end
endmodule

// File: rtl/lane_steer.sv
module lane_steer
    import lane_steer_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int NLANE = DATA_W / BYTE_W,
    localparam int OFS_W = $clog2(NLANE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ex_adv,
    input  logic              ex_byte,
    input  logic              ex_half,
    input  logic [OFS_W-1:0]  ex_opa_lo,
    input  logic [OFS_W-1:0]  ex_opb_lo,
    input  logic [DATA_W-1:0] ex_store_val,
    output logic [OFS_W-1:0]  ex_lane_ofs,
    output logic [DATA_W-1:0] ex_wdata,
    output logic [NLANE-1:0]  ex_ben,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [NLANE-1:0]  mem_ben,
    input  logic [OFS_W-1:0]  wb_lane_ofs,
    input  logic              wb_byte,
    input  logic              wb_half,
    input  logic [DATA_W-1:0] wb_rdata_raw,
    output logic [DATA_W-1:0] wb_rdata
);
    acc_size_e ex_size;
    acc_size_e wb_size;

    assign ex_size = decode_size(ex_byte, ex_half);
    assign wb_size = decode_size(wb_byte, wb_half);

    lane_offset #(.OFS_W(OFS_W)) u_ofs (
        .opa_lo   (ex_opa_lo),
        .opb_lo   (ex_opb_lo),
        .lane_ofs (ex_lane_ofs)
    );

    store_mirror #(.DATA_W(DATA_W)) u_mirror (
        .size      (ex_size),
        .lane_ofs  (ex_lane_ofs),
        .store_val (ex_store_val),
        .wdata     (ex_wdata),
        .ben       (ex_ben)
    );

    mem_stage_reg #(.DATA_W(DATA_W), .NLANE(NLANE)) u_memreg (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv       (ex_adv),
        .wdata_in  (ex_wdata),
        .ben_in    (ex_ben),
        .wdata_out (mem_wdata),
        .ben_out   (mem_ben)
    );

    load_align #(.DATA_W(DATA_W)) u_align (
        .size     (wb_size),
        .lane_ofs (wb_lane_ofs),
        .raw      (wb_rdata_raw),
        .rdata    (wb_rdata)
    );
endmodule

// File: rtl/lane_steer_chk.sv
module lane_steer_chk #(
    parameter int DATA_W = 32,
    localparam int NLANE = DATA_W / 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ex_adv,
    input logic              ex_byte,
    input logic              ex_half,
    input logic [DATA_W-1:0] ex_store_val,
    input logic [DATA_W-1:0] ex_wdata,
    input logic [NLANE-1:0]  ex_ben,
    input logic [DATA_W-1:0] mem_wdata,
    input logic [NLANE-1:0]  mem_ben,
    input logic              wb_byte,
    input logic              wb_half,
    input logic [DATA_W-1:0] wb_rdata
);
    assert_byte_one_lane_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ex_byte |-> $countones(ex_ben) == 1);

    assert_half_two_lanes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_half && !ex_byte) |-> $countones(ex_ben) == 2);

    assert_word_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ex_half && !ex_byte) |-> (ex_ben == '1 && ex_wdata == ex_store_val));

    assert_mem_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ex_adv |=> (mem_wdata == $past(ex_wdata) && mem_ben == $past(ex_ben)));

    assert_mem_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_adv |=> ($stable(mem_wdata) && $stable(mem_ben)));

    assert_byte_zero_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wb_byte |-> wb_rdata[DATA_W-1:8] == '0);

    assert_half_zero_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_half && !wb_byte) |-> wb_rdata[DATA_W-1:16] == '0);
endmodule

bind lane_steer lane_steer_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ex_adv       (ex_adv),
    .ex_byte      (ex_byte),
    .ex_half      (ex_half),
    .ex_store_val (ex_store_val),
    .ex_wdata     (ex_wdata),
    .ex_ben       (ex_ben),
    .mem_wdata    (mem_wdata),
    .mem_ben      (mem_ben),
    .wb_byte      (wb_byte),
    .wb_half      (wb_half),
    .wb_rdata     (wb_rdata)
);

// File: tb/tb_lane_steer.sv
`timescale 1ns/1ps
module tb_lane_steer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ex_adv = 1'b0, ex_byte = 1'b0, ex_half = 1'b0;
    logic [1:0]  ex_opa_lo = '0, ex_opb_lo = '0;
    logic [31:0] ex_store_val = '0;
    logic [1:0]  ex_lane_ofs;
    logic [31:0] ex_wdata, mem_wdata, wb_rdata;
    logic [3:0]  ex_ben, mem_ben;
    logic [1:0]  wb_lane_ofs = '0;
    logic        wb_byte = 1'b0, wb_half = 1'b0;
    logic [31:0] wb_rdata_raw = '0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    lane_steer dut (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic t_reset();
        check("R6 reset wdata", mem_wdata, 32'h0);
        check("R6 reset ben", {28'h0, mem_ben}, 32'h0);
    endtask

    task automatic t_offset();
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                @(negedge clk);
                ex_opa_lo = 2'(a); ex_opb_lo = 2'(b);
                #1 check("R1 offset", {30'h0, ex_lane_ofs}, 32'((a + b) % 4));
            end
        end
    endtask

    task automatic t_byte_store();
        for (int o = 0; o < 4; o++) begin
            @(negedge clk);
            ex_byte = 1; ex_half = 0; ex_store_val = 32'h1234_56A5;
            ex_opa_lo = 2'(o); ex_opb_lo = 2'd0;
            #1;
            check("R2 byte data", ex_wdata, 32'hA5A5_A5A5);
            check("R2 byte ben", {28'h0, ex_ben}, 32'(4'b1000 >> o));
        end
    endtask

    task automatic t_half_store();
        for (int o = 0; o < 4; o++) begin
            @(negedge clk);
            ex_byte = 0; ex_half = 1; ex_store_val = 32'hDEAD_BE01;
            ex_opa_lo = 2'd1; ex_opb_lo = 2'(o + 3);
            #1;
            check("R3 half data", ex_wdata, 32'hBE01_BE01);
            check("R3 half ben", {28'h0, ex_ben}, (o < 2) ? 32'hC : 32'h3);
        end
    endtask

    task automatic t_word_store();
        @(negedge clk);
        ex_byte = 0; ex_half = 0; ex_store_val = 32'hCAFE_F00D;
        ex_opa_lo = 2'd2; ex_opb_lo = 2'd3;
        #1;
        check("R4 word data", ex_wdata, 32'hCAFE_F00D);
        check("R4 word ben", {28'h0, ex_ben}, 32'hF);
    endtask

    task automatic t_priority();
        @(negedge clk);
        ex_byte = 1; ex_half = 1; ex_store_val = 32'h0000_7E3C;
        ex_opa_lo = 2'd1; ex_opb_lo = 2'd1;
        #1;
        check("R5 priority data", ex_wdata, 32'h3C3C_3C3C);
        check("R5 priority ben", {28'h0, ex_ben}, 32'h2);
    endtask

    task automatic t_mem_reg();
        @(negedge clk);
        ex_adv = 1; ex_byte = 1; ex_half = 0; ex_store_val = 32'h0000_0011;
        ex_opa_lo = 2'd3; ex_opb_lo = 2'd0;
        @(posedge clk); #1;
        check("R6 capture data", mem_wdata, 32'h1111_1111);
        check("R6 capture ben", {28'h0, mem_ben}, 32'h1);
        @(negedge clk);
        ex_adv = 0; ex_byte = 0; ex_store_val = 32'h9999_8888;
        @(posedge clk); #1;
        check("R6 hold data", mem_wdata, 32'h1111_1111);
        check("R6 hold ben", {28'h0, mem_ben}, 32'h1);
        @(negedge clk);
        ex_adv = 1;
        @(posedge clk); #1;
        check("R6 recapture data", mem_wdata, 32'h9999_8888);
        check("R6 recapture ben", {28'h0, mem_ben}, 32'hF);
        @(negedge clk);
        ex_adv = 0;
    endtask

    task automatic t_loads();
        logic [31:0] raw;
        raw = 32'hA1B2_C3D4;
        for (int o = 0; o < 4; o++) begin
            @(negedge clk);
            wb_rdata_raw = raw; wb_lane_ofs = 2'(o);
            wb_byte = 1; wb_half = 1;
            #1 check("R7 byte load", wb_rdata, {24'h0, raw[31 - 8*o -: 8]});
            wb_byte = 0; wb_half = 1;
            #1 check("R8 half load", wb_rdata, {16'h0, (o < 2) ? raw[31:16] : raw[15:0]});
            wb_byte = 0; wb_half = 0;
            #1 check("R9 word load", wb_rdata, raw);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 t_reset();
        @(negedge clk) rst_n = 1;
        t_offset();
        t_byte_store();
        t_half_store();
        t_word_store();
        t_priority();
        t_mem_reg();
        t_loads();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual=timeout expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule